// File: doc/BRIEF.md
# Board Control and Status Register Bank

This block holds the board's control bits in four 16-bit registers and makes the board's status inputs visible to software through a small synchronous register bus. The bus has a byte address, a write strobe with write data, and a read strobe whose result is returned on the read-data port one clock later. Every control register has two addresses. A write to the first address turns on each bit written as one. A write to the second address turns off each bit written as one. Bits written as zero keep their value, so software can change one bit without reading the register first and without racing other code that owns other bits.

The register outputs drive the board's control pins directly. Each register has its own reset pattern, so every pin comes out of reset in its safe state. Two status registers show the board input pins, a DIP switch and the live DMA request. Each of these inputs passes through a two-flop synchroniser before it can be read. An identification register combines a hard-wired design revision with two strap-pin fields.

Top module: `board_ctl_bank`

## Requirements
- R1: After reset the control registers hold 0x007C (register A), 0x3E1D (B), 0x9D5B (C) and 0x0033 (D). A read returns these values and the control output ports show them, with port `ctl_d` carrying the low 6 bits of D.
- R2: A write to a register's set address (A 0x04, B 0x08, C 0x0C, D 0x10) sets every bit whose write-data bit is 1 and leaves every other bit unchanged.
- R3: A write to a register's clear address (A 0x06, B 0x0A, C 0x0E, D 0x12) clears every bit whose write-data bit is 1 and leaves every other bit unchanged.
- R4: A read of either the set address or the clear address of a register returns the register's current contents.
- R5: Bits [15:6] of register D always read 0, and writes to them have no effect.
- R6: A read of address 0x00 returns the design revision parameter in bits [15:8], `strap_cpu` in bits [7:4] and `strap_base` in bits [3:0].
- R7: A read of address 0x02 returns the DIP switch in bits [7:0], the DMA request in bit 8 and 0 in bits [15:9]. These inputs pass through a two-flop synchroniser, so a change made before clock edge k is first returned by a read strobe sampled at edge k+2.
- R8: A read of address 0x14 returns the 13 board input pins in bits [12:0] and 0 in bits [15:13], through the same synchroniser.
- R9: Writes to the read-only addresses 0x00, 0x02 and 0x14, and to unmapped addresses, change no control register.
- R10: `bus_rdata` is loaded at the clock edge where `bus_rd` is sampled high, and holds its value at every other edge. A read of an unmapped address returns 0, and `bus_rdata` is 0 after reset.
- R11: A control register changes only at an edge where a write strobe hits one of its two addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| strap_cpu | input | 4 | Strap pins for the processor board identity |
| strap_base | input | 4 | Strap pins for the base board identity |
| dip_sw | input | 8 | DIP switch inputs |
| dma_req | input | 1 | Live DMA request level |
| board_in | input | 13 | Board status inputs |
| ctl_a | output | 16 | Control register A |
| ctl_b | output | 16 | Control register B |
| ctl_c | output | 16 | Control register C |
| ctl_d | output | 6 | Implemented bits of control register D |

## Verification
The assertions assume that one access hits only one address, so a set and a clear of the same register never happen in the same cycle. The stimulus meets this because the bus carries a single address per cycle. The synchroniser check assumes the status inputs are sampled values, not glitches. The bench changes these inputs only at the falling edge and keeps them steady for several cycles before it reads them. The strap pins are treated as static, and the bench holds them constant for the whole run.

// File: rtl/scbank_pkg.sv
package scbank_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int N_CTRL  = 4;
  localparam int ST1_W   = 13;
  localparam int DIP_W   = 8;
  localparam int STRAP_W = 4;
  localparam int D_BITS  = 6;

  localparam logic [ADDR_W-1:0] OFF_IDENT = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT2 = 5'h02;
  localparam logic [ADDR_W-1:0] OFF_STAT1 = 5'h14;
  localparam int                CTRL_BASE = 4;
  localparam int                CTRL_STEP = 4;

  typedef logic [DATA_W-1:0] word_t;

  localparam word_t CTRL_RST  [N_CTRL] = '{16'h007C, 16'h3E1D, 16'h9D5B, 16'h0033};
  localparam word_t CTRL_MASK [N_CTRL] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h003F};

  function automatic logic [ADDR_W-1:0] set_off(input int idx);
    return ADDR_W'(CTRL_BASE + CTRL_STEP * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] clr_off(input int idx);
    return ADDR_W'(CTRL_BASE + CTRL_STEP * idx + 2);
  endfunction
endpackage

// File: rtl/scb_sync.sv
module scb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  // Counts edges since reset so the latency check never looks before reset
  logic [1:0] fill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            fill_q <= 2'd0;
    else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end

  a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/scb_setclr_reg.sv
module scb_setclr_reg #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    RST  = '0,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         en;

  assign en = set_we | clr_we;

  always_comb begin
    q_nxt = q_r;
    if (set_we)      q_nxt = q_r | (wdata & MASK);
    else if (clr_we) q_nxt = q_r & ~wdata;
    q_nxt = q_nxt & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST & MASK;
    else if (en) q_r <= q_nxt;
  end

  assign q = q_r;

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));

  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(q));
endmodule

// File: rtl/scb_rdmux.sv
module scb_rdmux
  import scbank_pkg::*;
(
  input  logic [ADDR_W-1:0]             addr,
  input  logic [N_CTRL-1:0][DATA_W-1:0] ctrl,
  input  logic [DATA_W-1:0]             ident,
  input  logic [DATA_W-1:0]             stat1,
  input  logic [DATA_W-1:0]             stat2,
  output logic [DATA_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_IDENT: rdata = ident;
      OFF_STAT2: rdata = stat2;
      OFF_STAT1: rdata = stat1;
      default:   rdata = '0;
    endcase
    for (int i = 0; i < N_CTRL; i++) begin
      if (addr == set_off(i) || addr == clr_off(i)) rdata = ctrl[i];
    end
  end
endmodule

// File: rtl/board_ctl_bank.sv
module board_ctl_bank
  import scbank_pkg::*;
#(
  parameter logic [7:0] DESIGN_REV = 8'hA5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [STRAP_W-1:0]  strap_cpu,
  input  logic [STRAP_W-1:0]  strap_base,
  input  logic [DIP_W-1:0]    dip_sw,
  input  logic                dma_req,
  input  logic [ST1_W-1:0]    board_in,
  output logic [DATA_W-1:0]   ctl_a,
  output logic [DATA_W-1:0]   ctl_b,
  output logic [DATA_W-1:0]   ctl_c,
  output logic [D_BITS-1:0]   ctl_d
);
  localparam int SYNC_W = ST1_W + DIP_W + 1;

  logic [N_CTRL-1:0][DATA_W-1:0] ctrl_q;
  logic [SYNC_W-1:0]             sync_q;
  logic [DATA_W-1:0]             ident_w, stat1_w, stat2_w, rd_nxt;
  logic [DATA_W-1:0]             rdata_q;

  // Input synchroniser for all live status inputs
  scb_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({board_in, dma_req, dip_sw}),
    .q     (sync_q)
  );

  // One set/clear register per control word
  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    logic set_hit, clr_hit;
    assign set_hit = bus_wr && (bus_addr == set_off(g));
    assign clr_hit = bus_wr && (bus_addr == clr_off(g));
    scb_setclr_reg #(.W(DATA_W), .RST(CTRL_RST[g]), .MASK(CTRL_MASK[g])) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_hit),
      .clr_we (clr_hit),
      .wdata  (bus_wdata),
      .q      (ctrl_q[g])
    );
  end

  assign ident_w = {DESIGN_REV, strap_cpu, strap_base};
  assign stat2_w = {{(DATA_W-DIP_W-1){1'b0}}, sync_q[DIP_W], sync_q[DIP_W-1:0]};
  assign stat1_w = {{(DATA_W-ST1_W){1'b0}}, sync_q[SYNC_W-1:DIP_W+1]};

  scb_rdmux u_rdmux (
    .addr  (bus_addr),
    .ctrl  (ctrl_q),
    .ident (ident_w),
    .stat1 (stat1_w),
    .stat2 (stat2_w),
    .rdata (rd_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_nxt;
  end

  assign bus_rdata = rdata_q;
  assign ctl_a = ctrl_q[0];
  assign ctl_b = ctrl_q[1];
  assign ctl_c = ctrl_q[2];
  assign ctl_d = ctrl_q[3][D_BITS-1:0];

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r5_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == set_off(3) || bus_addr == clr_off(3)))
      |=> (bus_rdata[DATA_W-1:D_BITS] == '0));

  a_r9_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFF_IDENT || bus_addr == OFF_STAT1 || bus_addr == OFF_STAT2))
      |=> ($stable(ctl_a) && $stable(ctl_b) && $stable(ctl_c) && $stable(ctl_d)));
endmodule

// File: tb/test_board_ctl_bank.sv
`timescale 1ns/1ps
module test_board_ctl_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [3:0]  strap_cpu, strap_base;
  logic [7:0]  dip_sw;
  logic        dma_req;
  logic [12:0] board_in;
  logic [15:0] ctl_a, ctl_b, ctl_c;
  logic [5:0]  ctl_d;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  board_ctl_bank #(.DESIGN_REV(8'hA5)) i_board_ctl_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .strap_cpu(strap_cpu), .strap_base(strap_base), .dip_sw(dip_sw),
    .dma_req(dma_req), .board_in(board_in), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .ctl_c(ctl_c), .ctl_d(ctl_d)
  );

  // {write, addr, wdata, expected read}
  localparam int NV = 28;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'h04, 16'h0000, 16'h007C},  // R1
    {1'b0, 5'h0A, 16'h0000, 16'h3E1D},  // R1 R4
    {1'b0, 5'h0C, 16'h0000, 16'h9D5B},  // R1
    {1'b0, 5'h12, 16'h0000, 16'h0033},  // R1 R4
    {1'b0, 5'h00, 16'h0000, 16'hA53C},  // R6
    {1'b0, 5'h02, 16'h0000, 16'h015A},  // R7
    {1'b0, 5'h14, 16'h0000, 16'h1ABC},  // R8
    {1'b1, 5'h04, 16'h8001, 16'h0000},  // R2
    {1'b0, 5'h06, 16'h0000, 16'h807D},  // R2 R4
    {1'b1, 5'h06, 16'h0014, 16'h0000},  // R3
    {1'b0, 5'h04, 16'h0000, 16'h8069},  // R3
    {1'b1, 5'h0A, 16'hFFFF, 16'h0000},  // R3
    {1'b0, 5'h08, 16'h0000, 16'h0000},  // R3
    {1'b1, 5'h08, 16'h2400, 16'h0000},  // R2
    {1'b0, 5'h0A, 16'h0000, 16'h2400},  // R2
    {1'b1, 5'h0E, 16'h8000, 16'h0000},  // R3
    {1'b0, 5'h0C, 16'h0000, 16'h1D5B},  // R3
    {1'b1, 5'h10, 16'hFFC0, 16'h0000},  // R5
    {1'b0, 5'h12, 16'h0000, 16'h0033},  // R5
    {1'b1, 5'h10, 16'hFFFF, 16'h0000},  // R2 R5
    {1'b0, 5'h10, 16'h0000, 16'h003F},  // R5
    {1'b1, 5'h12, 16'h0003, 16'h0000},  // R3
    {1'b0, 5'h10, 16'h0000, 16'h003C},  // R3
    {1'b1, 5'h00, 16'hFFFF, 16'h0000},  // R9
    {1'b1, 5'h14, 16'hFFFF, 16'h0000},  // R9
    {1'b1, 5'h1E, 16'hFFFF, 16'h0000},  // R9
    {1'b0, 5'h04, 16'h0000, 16'h8069},  // R9
    {1'b0, 5'h1E, 16'h0000, 16'h0000}   // R10 unmapped
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [4:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = wr;
    bus_rd    = ~wr;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    strap_cpu = 4'h3; strap_base = 4'hC;
    dip_sw = 8'h5A; dma_req = 1'b1; board_in = 13'h1ABC;
    repeat (3) @(negedge clk);
    check("R1 ctl_a", ctl_a, 16'h007C);
    check("R1 ctl_b", ctl_b, 16'h3E1D);
    check("R1 ctl_c", ctl_c, 16'h9D5B);
    check("R1 ctl_d", {10'd0, ctl_d}, 16'h0033);
    check("R10 rdata reset", bus_rdata, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][37], VEC[i][36:32], VEC[i][31:16]);
      if (!VEC[i][37]) check($sformatf("R1-table vec %0d", i), bus_rdata, VEC[i][15:0]);
    end

    // Output ports after the table
    check("R2 ctl_a port", ctl_a, 16'h8069);
    check("R11 ctl_b port", ctl_b, 16'h2400);
    check("R11 ctl_c port", ctl_c, 16'h1D5B);
    check("R5 ctl_d port", {10'd0, ctl_d}, 16'h003C);

    // R10: read data holds without strobe
    bus_addr = 5'h00;
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, 16'h0000);

    // R7: synchroniser latency, read strobe held three edges
    dip_sw = 8'hA5; dma_req = 1'b0;
    bus_addr = 5'h02; bus_rd = 1'b1;
    @(negedge clk); check("R7 edge1 old", bus_rdata, 16'h015A);
    @(negedge clk); check("R7 edge2 old", bus_rdata, 16'h015A);
    @(negedge clk); check("R7 edge3 new", bus_rdata, 16'h00A5);
    bus_rd = 1'b0;

    // R8: status 1 change with all pins high
    board_in = 13'h1FFF;
    repeat (3) @(negedge clk);
    bus_op(1'b0, 5'h14, 16'h0);
    check("R8 all ones", bus_rdata, 16'h1FFF);

    // R2: write strobe with zero data changes nothing
    bus_op(1'b1, 5'h0C, 16'h0000);
    check("R2 zero set", ctl_c, 16'h1D5B);

    // R1: reset mid-run restores patterns
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 rerst ctl_a", ctl_a, 16'h007C);
    check("R1 rerst ctl_d", {10'd0, ctl_d}, 16'h0033);
    check("R10 rerst rdata", bus_rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
  end
endmodule